// File: doc/BRIEF.md
# Indexed-Access Nesting Interrupt Controller

This block arbitrates up to 128 interrupt sources onto a single processor interrupt line. Software never writes wide per-source bitmasks. It first writes a source index into a select register. Every mode, vector, enable and pending command that follows then acts on that one source alone. Each source keeps a 3-bit priority, a trigger type, a 32-bit vector, an enable bit and a latched pending bit.

The processor acknowledges an interrupt by reading the acknowledge-vector register. That read returns the winning source's vector, pushes the source's priority and index onto a nesting stack up to eight entries deep, and clears the source's latched pending bit. Only a source whose priority is strictly above the top of the stack can raise the line again. An end-of-interrupt write pops one level. When no interrupt can be taken, the acknowledge read returns a programmable spurious vector and the stack does not move.

The nesting stack is tracked by a small state machine with three states:
- `NS_IDLE`: the stack is empty.
- `NS_NESTED`: between one and seven levels are held.
- `NS_SATURATED`: all eight levels are held.

Its transitions are:
- `T_FIRST_ACK`: from `NS_IDLE` to `NS_NESTED` on an acknowledge.
- `T_FILL`: from `NS_NESTED` to `NS_SATURATED` on the acknowledge that takes the eighth level.
- `T_UNFILL`: from `NS_SATURATED` to `NS_NESTED` on an end-of-interrupt.
- `T_LAST_EOI`: from `NS_NESTED` to `NS_IDLE` on the end-of-interrupt that pops the last level.

Any other event leaves the state where it is.

Top module: `vic_indirect`

## Requirements
- R1: After reset all sources are disabled and not pending, every mode and vector reads 0, the stack is empty, the spurious vector is 0, `irq_out` is low, and the status register (0x18) reads 0.
- R2: Writing offset 0x00 selects source `wdata[6:0]`, and reading it returns that index. The mode register at 0x04 reads and writes the selected source: priority in bits 2:0, trigger in bits 6:5, all other bits read 0. The vector register at 0x08 reads and writes the selected source's 32-bit vector.
- R3: A write with bit 0 set to 0x40 enables the selected source, and the same write to 0x44 disables it. A write to 0x40 with bit 0 clear has no effect. Bit 0 of offset 0x30 reads the selected source's enable.
- R4: A write with bit 0 set to 0x4C forces the selected source's latched pending bit, and the same write to 0x48 clears it. Offsets 0x20, 0x24, 0x28 and 0x2C read pending for sources 0-31, 32-63, 64-95 and 96-127, with source n in bit n mod 32.
- R5: The trigger codes are 0 = level-high, 1 = level-low, 2 = rising edge and 3 = falling edge. A level source reads pending while its input is at the active level. An edge source latches pending on its edge and holds it until it is acknowledged or cleared. An input change shows in pending one clock after it is sampled.
- R6: `irq_out` is high exactly when some enabled pending source has a priority strictly greater than the top of the stack (any priority counts when the stack is empty) and the stack is not full.
- R7: The winner is the enabled pending source with the highest priority, and among equal priorities the lowest index wins. A read of 0x10 while `irq_out` is high returns the winner's vector.
- R8: A read of 0x10 while `irq_out` is high pushes the winner and clears its latched pending bit. Status (0x18) then reads bit 31 set with the top-of-stack source index in bits 6:0.
- R9: Offset 0x3C holds the spurious vector. A read of 0x10 while `irq_out` is low returns it and leaves the stack unchanged.
- R10: A write to 0x38 pops one stack level, and on an empty stack it does nothing. Eight such writes from any state leave the stack empty.
- R11: A higher-priority source preempts a lower one that is still in service. The stack holds at most eight levels, and while it is full `irq_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 128 | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (0x10 read has side effects) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from addr and state |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench first configures eight sources at rising priorities and acknowledges each in turn to fill the stack. It then confirms that the line stays low while full, and that eight end-of-interrupt writes release it. A stack that wrapped or dropped a level would leave the line stuck or the status index wrong. Two equal-priority sources are raised together: an arbiter that lets ties replace the current pick would return the higher index, and one that used a non-strict compare against the stack top would re-raise the line for the second source while the first is in service. It also checks that an extra end-of-interrupt on an empty stack does no harm, that a rising-edge source stays pending after its input falls until it is acknowledged, and that a spurious acknowledge read does not push a stack level.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        TRG_LVL_HI = 2'd0,
        TRG_LVL_LO = 2'd1,
        TRG_RISE   = 2'd2,
        TRG_FALL   = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        NS_IDLE      = 2'd0,
        NS_NESTED    = 2'd1,
        NS_SATURATED = 2'd2
    } nest_state_e;

    localparam logic [7:0] A_SEL    = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h04;
    localparam logic [7:0] A_VEC    = 8'h08;
    localparam logic [7:0] A_ACKVEC = 8'h10;
    localparam logic [7:0] A_STAT   = 8'h18;
    localparam logic [7:0] A_PEND0  = 8'h20;
    localparam logic [7:0] A_ENRD   = 8'h30;
    localparam logic [7:0] A_EOI    = 8'h38;
    localparam logic [7:0] A_SPUR   = 8'h3C;
    localparam logic [7:0] A_EN     = 8'h40;
    localparam logic [7:0] A_DIS    = 8'h44;
    localparam logic [7:0] A_CLR    = 8'h48;
    localparam logic [7:0] A_SET    = 8'h4C;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 32,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [SEL_W-1:0]   sel,
    input  logic               wr_mode,
    input  trig_e              mode_trig,
    input  logic [PRIO_W-1:0]  mode_prio,
    input  logic               wr_vec,
    input  logic [VEC_W-1:0]   vec_wdata,
    input  logic               cmd_en,
    input  logic               cmd_dis,
    input  logic               cmd_set,
    input  logic               cmd_clr,
    input  logic               ack_valid,
    input  logic [SEL_W-1:0]   ack_idx,
    output logic [PRIO_W-1:0]  prio_o [NUM_SRC],
    output trig_e              trig_o [NUM_SRC],
    output logic [VEC_W-1:0]   vec_o  [NUM_SRC],
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o
);
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            logic  hit;
            logic  sq;
            logic  pq;
            logic  edge_hit;
            trig_e trig_q;

            assign hit = (sel == SEL_W'(i));

            always_comb begin
                unique case (trig_q)
                    TRG_RISE: edge_hit = src_in[i] & ~sq;
                    TRG_FALL: edge_hit = ~src_in[i] & sq;
                    default:  edge_hit = 1'b0;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sq        <= 1'b0;
                    pq        <= 1'b0;
                    trig_q    <= TRG_LVL_HI;
                    prio_o[i] <= '0;
                    vec_o[i]  <= '0;
                    en_o[i]   <= 1'b0;
                end else begin
                    sq <= src_in[i];
                    if (wr_mode && hit) begin
                        trig_q    <= mode_trig;
                        prio_o[i] <= mode_prio;
                    end
                    if (wr_vec && hit) vec_o[i] <= vec_wdata;
                    if (cmd_en && hit)       en_o[i] <= 1'b1;
                    else if (cmd_dis && hit) en_o[i] <= 1'b0;
                    if (cmd_clr && hit)                      pq <= 1'b0;
                    else if (edge_hit || (cmd_set && hit))   pq <= 1'b1;
                    else if (ack_valid && ack_idx == SEL_W'(i)) pq <= 1'b0;
                end
            end

            assign trig_o[i] = trig_q;
            assign pend_o[i] = pq | ((trig_q == TRG_LVL_HI) & sq)
                                  | ((trig_q == TRG_LVL_LO) & ~sq);
        end
    endgenerate
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 3,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [PRIO_W-1:0]  prio [NUM_SRC],
    output logic               any,
    output logic [SEL_W-1:0]   win_idx,
    output logic [PRIO_W-1:0]  win_prio
);
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!any || prio[i] > win_prio)) begin
                any      = 1'b1;
                win_idx  = SEL_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack
    import vic_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int SEL_W  = 7,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [SEL_W-1:0]  push_idx,
    input  logic              pop,
    output logic              top_valid,
    output logic              full,
    output logic [PRIO_W-1:0] top_prio,
    output logic [SEL_W-1:0]  top_idx,
    output logic [CNT_W-1:0]  depth,
    output nest_state_e       state
);
    nest_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  top_ptr;
    logic [PRIO_W-1:0] prio_stk [DEPTH];
    logic [SEL_W-1:0]  idx_stk  [DEPTH];
    logic              do_push, do_pop;

    assign do_push = push && (state_q != NS_SATURATED);
    assign do_pop  = pop  && (state_q != NS_IDLE);
    assign top_ptr = cnt_q - CNT_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NS_IDLE:      if (do_push) state_d = NS_NESTED;
            NS_NESTED: begin
                if (do_push && cnt_q == CNT_W'(DEPTH - 1)) state_d = NS_SATURATED;
                else if (do_pop && cnt_q == CNT_W'(1))     state_d = NS_IDLE;
            end
            NS_SATURATED: if (do_pop) state_d = NS_NESTED;
            default:      state_d = NS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NS_IDLE;
            cnt_q   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_stk[i] <= '0;
                idx_stk[i]  <= '0;
            end
        end else begin
            state_q <= state_d;
            if (do_push) begin
                prio_stk[cnt_q[PTR_W-1:0]] <= push_prio;
                idx_stk[cnt_q[PTR_W-1:0]]  <= push_idx;
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (do_pop) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        top_valid = (state_q != NS_IDLE);
        full      = (state_q == NS_SATURATED);
        top_prio  = top_valid ? prio_stk[top_ptr[PTR_W-1:0]] : '0;
        top_idx   = top_valid ? idx_stk[top_ptr[PTR_W-1:0]]  : '0;
        depth     = cnt_q;
        state     = state_q;
    end
endmodule

// File: rtl/vic_indirect.sv
module vic_indirect
    import vic_pkg::*;
#(
    parameter int NUM_SRC    = 128,
    parameter int PRIO_W     = 3,
    parameter int NEST_DEPTH = 8,
    localparam int SEL_W     = $clog2(NUM_SRC),
    localparam int CNT_W     = $clog2(NEST_DEPTH + 1),
    localparam int NWORDS    = (NUM_SRC + DATA_W - 1) / DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  spur_q;
    logic [PRIO_W-1:0]  prio_a [NUM_SRC];
    trig_e              trig_a [NUM_SRC];
    logic [DATA_W-1:0]  vec_a  [NUM_SRC];
    logic [NUM_SRC-1:0] en_v, pend_v, req;
    logic               req_any;
    logic               any;
    logic [SEL_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic               top_valid, full;
    logic [PRIO_W-1:0]  top_prio;
    logic [SEL_W-1:0]   top_idx;
    logic [CNT_W-1:0]   nest_depth;
    nest_state_e        nest_state;
    logic               ack_rd, ack_valid, eoi_wr;
    logic [NWORDS*DATA_W-1:0] pend_pad;

    wire wr_sel  = bus_wr && bus_addr == A_SEL;
    wire wr_mode = bus_wr && bus_addr == A_MODE;
    wire wr_vec  = bus_wr && bus_addr == A_VEC;
    wire wr_spur = bus_wr && bus_addr == A_SPUR;
    wire cmd_en  = bus_wr && bus_addr == A_EN  && bus_wdata[0];
    wire cmd_dis = bus_wr && bus_addr == A_DIS && bus_wdata[0];
    wire cmd_clr = bus_wr && bus_addr == A_CLR && bus_wdata[0];
    wire cmd_set = bus_wr && bus_addr == A_SET && bus_wdata[0];

    assign ack_rd    = bus_rd && bus_addr == A_ACKVEC;
    assign eoi_wr    = bus_wr && bus_addr == A_EOI;
    assign ack_valid = ack_rd && irq_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
        end else begin
            if (wr_sel)  sel_q  <= bus_wdata[SEL_W-1:0];
            if (wr_spur) spur_q <= bus_wdata;
        end
    end

    vic_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .sel       (sel_q),
        .wr_mode   (wr_mode),
        .mode_trig (trig_e'(bus_wdata[6:5])),
        .mode_prio (bus_wdata[PRIO_W-1:0]),
        .wr_vec    (wr_vec),
        .vec_wdata (bus_wdata),
        .cmd_en    (cmd_en),
        .cmd_dis   (cmd_dis),
        .cmd_set   (cmd_set),
        .cmd_clr   (cmd_clr),
        .ack_valid (ack_valid),
        .ack_idx   (win_idx),
        .prio_o    (prio_a),
        .trig_o    (trig_a),
        .vec_o     (vec_a),
        .en_o      (en_v),
        .pend_o    (pend_v)
    );

    assign req     = en_v & pend_v;
    assign req_any = |req;

    vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .req      (req),
        .prio     (prio_a),
        .any      (any),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    vic_nest_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_valid),
        .push_prio (win_prio),
        .push_idx  (win_idx),
        .pop       (eoi_wr),
        .top_valid (top_valid),
        .full      (full),
        .top_prio  (top_prio),
        .top_idx   (top_idx),
        .depth     (nest_depth),
        .state     (nest_state)
    );

    assign irq_out = any && !full && (!top_valid || win_prio > top_prio);

    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_SRC-1:0] = pend_v;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SEL:    bus_rdata[SEL_W-1:0] = sel_q;
            A_MODE: begin
                bus_rdata[6:5]        = trig_a[sel_q];
                bus_rdata[PRIO_W-1:0] = prio_a[sel_q];
            end
            A_VEC:    bus_rdata = vec_a[sel_q];
            A_ACKVEC: bus_rdata = irq_out ? vec_a[win_idx] : spur_q;
            A_STAT: begin
                if (top_valid) begin
                    bus_rdata[31]        = 1'b1;
                    bus_rdata[SEL_W-1:0] = top_idx;
                end
            end
            A_ENRD:   bus_rdata[0] = en_v[sel_q];
            A_SPUR:   bus_rdata = spur_q;
            default: begin
                for (int k = 0; k < NWORDS; k++)
                    if (bus_addr == A_PEND0 + 8'(4 * k))
                        bus_rdata = pend_pad[k*DATA_W +: DATA_W];
            end
        endcase
    end
endmodule

// File: rtl/vic_indirect_chk.sv
module vic_indirect_chk
    import vic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic             req_any,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic [31:0]      spur,
    input logic [CNT_W-1:0] depth,
    input nest_state_e      state
);
    wire ack_rd = bus_rd && bus_addr == A_ACKVEC;
    wire eoi    = bus_wr && bus_addr == A_EOI;

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> req_any);

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

    assert_full_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_SATURATED) |-> !irq_out);

    assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_IDLE) == (depth == '0));

    assert_ack_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_out) |=> depth == $past(depth) + CNT_W'(1));

    assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_out) |-> bus_rdata == spur);

    assert_spurious_nopush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_out) |=> $stable(depth));

    assert_eoi_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && depth != '0) |=> depth == $past(depth) - CNT_W'(1));

    assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && depth == '0) |=> depth == '0);
endmodule

bind vic_indirect vic_indirect_chk #(.DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .req_any   (req_any),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .spur      (spur_q),
    .depth     (nest_depth),
    .state     (nest_state)
);

// File: tb/sim_vic_indirect.sv
`timescale 1ns/1ps
module sim_vic_indirect;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_in = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_out;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    vic_indirect u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // monitor: compares every read against the scoreboard head
    always @(negedge clk) begin
        #1;
        if (bus_rd) begin
            exp_t e;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty addr=%h got=%h expected=none", bus_addr, bus_rdata);
            end else begin
                e = exp_q.pop_front();
                if (bus_rdata !== e.val) begin
                    n_fail++;
                    $display("FAIL %s addr=%h got=%h expected=%h", e.tag, bus_addr, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drv(input int i, input logic v);
        @(negedge clk);
        src_in[i] = v;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        #1;
        n_chk++;
        if (irq_out !== e) begin
            n_fail++;
            $display("FAIL %s irq_out got=%b expected=%b", tag, irq_out, e);
        end
    endtask

    task automatic cfg(input int idx, input logic [31:0] mode, input logic [31:0] vec, input logic en);
        wr(8'h00, idx);
        wr(8'h04, mode);
        wr(8'h08, vec);
        if (en) wr(8'h40, 32'h1);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq low");
        rd(8'h10, 32'h0, "R1 spurious zero");
        rd(8'h18, 32'h0, "R1 status");
        rd(8'h20, 32'h0, "R1 pending");
        rd(8'h30, 32'h0, "R1 enable");
        rd(8'h04, 32'h0, "R1 mode");

        // R2 indexed mode/vector
        cfg(5, 32'h43, 32'hA5, 1'b0);
        cfg(6, 32'hFF, 32'h66, 1'b0);
        wr(8'h00, 5);
        rd(8'h00, 32'd5, "R2 select");
        rd(8'h04, 32'h43, "R2 mode src5");
        rd(8'h08, 32'hA5, "R2 vector src5");
        wr(8'h00, 6);
        rd(8'h04, 32'h67, "R2 mode mask src6");

        // R3 enable/disable
        wr(8'h00, 5);
        wr(8'h40, 32'h0);
        rd(8'h30, 32'h0, "R3 zero write ignored");
        wr(8'h40, 32'h1);
        rd(8'h30, 32'h1, "R3 enabled");
        wr(8'h44, 32'h1);
        rd(8'h30, 32'h0, "R3 disabled");
        wr(8'h40, 32'h1);

        // R4 set/clear on upper word
        wr(8'h00, 40);
        wr(8'h4C, 32'h1);
        rd(8'h24, 32'h100, "R4 set src40");
        wr(8'h48, 32'h1);
        rd(8'h24, 32'h0, "R4 clear src40");

        // R5 level-low and falling edge
        cfg(12, 32'h20, 32'hC, 1'b0);
        rd(8'h20, 32'h1000, "R5 level low");
        cfg(11, 32'h60, 32'hB, 1'b0);
        drv(11, 1'b1);
        drv(11, 1'b0);
        rd(8'h20, 32'h1800, "R5 falling latch");
        drv(12, 1'b1);
        rd(8'h20, 32'h0800, "R5 level low released");
        wr(8'h00, 11);
        wr(8'h48, 32'h1);
        rd(8'h20, 32'h0, "R4 clear src11");

        // R5/R6/R7/R8 rising source, level source
        chk_irq(1'b0, "R6 nothing pending");
        drv(5, 1'b1);
        chk_irq(1'b1, "R6 rising raises");
        drv(5, 1'b0);
        rd(8'h20, 32'h20, "R5 rising latch holds");
        cfg(9, 32'h01, 32'h99, 1'b1);
        drv(9, 1'b1);
        rd(8'h20, 32'h220, "R5 level high");
        rd(8'h10, 32'hA5, "R7 winner vector");
        rd(8'h18, 32'h8000_0005, "R8 status after ack");
        rd(8'h20, 32'h200, "R8 edge pending cleared");
        chk_irq(1'b0, "R6 lower prio blocked");
        rd(8'h10, 32'h0, "R9 spurious when blocked");
        rd(8'h18, 32'h8000_0005, "R9 no push");

        // R11 preemption
        cfg(20, 32'h07, 32'h77, 1'b1);
        drv(20, 1'b1);
        chk_irq(1'b1, "R11 preempt");
        rd(8'h10, 32'h77, "R11 preempt vector");
        rd(8'h18, 32'h8000_0014, "R11 nested status");
        wr(8'h38, 32'h0);
        rd(8'h18, 32'h8000_0005, "R10 pop one level");
        chk_irq(1'b1, "R6 level still high");
        drv(20, 1'b0);
        chk_irq(1'b0, "R6 level dropped");
        wr(8'h38, 32'h0);
        rd(8'h18, 32'h0, "R10 stack empty");
        chk_irq(1'b1, "R6 empty stack any prio");
        rd(8'h10, 32'h99, "R7 level vector");
        rd(8'h18, 32'h8000_0009, "R8 status src9");
        wr(8'h38, 32'h0);
        drv(9, 1'b0);
        chk_irq(1'b0, "R6 all quiet");

        // R7 ties, R6 strict compare
        cfg(30, 32'h04, 32'h30, 1'b1);
        cfg(31, 32'h04, 32'h31, 1'b1);
        drv(30, 1'b1);
        drv(31, 1'b1);
        rd(8'h10, 32'h30, "R7 tie lowest index");
        chk_irq(1'b0, "R6 equal prio blocked");
        drv(30, 1'b0);
        wr(8'h38, 32'h0);
        rd(8'h10, 32'h31, "R7 second of tie");
        drv(31, 1'b0);
        wr(8'h38, 32'h0);
        rd(8'h18, 32'h0, "R10 empty after ties");

        // R9 spurious programming
        wr(8'h3C, 32'hDEAD_BEEF);
        rd(8'h3C, 32'hDEAD_BEEF, "R9 spurious readback");
        rd(8'h10, 32'hDEAD_BEEF, "R9 spurious returned");
        rd(8'h18, 32'h0, "R9 stack untouched");

        // R11 fill the stack, R10 unlock with eight pops
        for (int k = 0; k < 8; k++) begin
            cfg(60 + k, k, 32'h100 + k, 1'b1);
            wr(8'h4C, 32'h1);
            rd(8'h10, 32'h100 + k, "R11 fill level");
        end
        rd(8'h18, 32'h8000_0043, "R11 full top src67");
        wr(8'h00, 60);
        wr(8'h4C, 32'h1);
        chk_irq(1'b0, "R11 full holds line low");
        for (int k = 0; k < 8; k++) wr(8'h38, 32'h0);
        rd(8'h18, 32'h0, "R10 eight pops empty");
        chk_irq(1'b1, "R10 line unlocked");
        rd(8'h10, 32'h100, "R10 src60 after unlock");
        wr(8'h38, 32'h0);
        wr(8'h38, 32'h0);
        rd(8'h18, 32'h0, "R10 pop on empty");
        chk_irq(1'b0, "R10 quiet after empty pop");
        wr(8'h00, 61);
        wr(8'h4C, 32'h1);
        rd(8'h10, 32'h101, "R10 push after empty pop");
        rd(8'h18, 32'h8000_003D, "R10 single level");
        wr(8'h38, 32'h0);
        rd(8'h18, 32'h0, "R10 final empty");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule